// File: doc/BRIEF.md
# Single-Clock FIFO Controller with Selectable Fall-Through Output

This block manages a single-clock first-in first-out queue held in a small register array. It steps its own write and read addresses and keeps an occupancy count. From that count it derives four handshake flags: full, empty, almost full and almost empty. The two "almost" thresholds come in on input pins and may be changed at any time, so software or a neighbouring block can tune the warning margins without rebuilding the design. Data width is the same on both sides of the queue.

A mode input picks how the oldest word is presented. In standard mode a consumer asserts a read request and receives the word on the following clock cycle from an output register. In fall-through mode the oldest word is already driven on the data output as soon as it has been stored, so the consumer sees it before it asks. An accepted read then retires that word and exposes the next one. Apart from that first-word presentation the two modes share the same pointer, flag and ordering behaviour. The mode is meant to be set once, while the queue is empty, and held there.

Top module: `fwft_fifo_ctrl`

## Requirements
- R1: After reset the queue is empty: empty_o=1, full_o=0, almost_empty_o=1, and in standard mode rd_data_o=0.
- R2: A write request while not full is accepted and raises the occupancy by one. full_o is 1 exactly when occupancy equals DEPTH, and empty_o is 1 exactly when occupancy is 0. The flags change in the cycle after the clock edge that accepts the operation.
- R3: A write request while full_o=1 is ignored: occupancy and stored contents do not change, and the dropped word is never read out.
- R4: A read request while empty_o=1 is ignored: occupancy stays 0 and, in standard mode, rd_data_o keeps its value.
- R5: In standard mode (fwft_mode_i=0) an accepted read loads the oldest stored word into rd_data_o at that clock edge. rd_data_o holds its value in every cycle without an accepted read.
- R6: In fall-through mode (fwft_mode_i=1) rd_data_o shows the oldest stored word whenever empty_o=0, with no read request. This includes the cycle right after a word is written into an empty queue. An accepted read makes the next word visible after the same edge.
- R7: Read and write requested together while neither full nor empty leave occupancy unchanged. When empty, only the write takes effect. When full, only the read takes effect.
- R8: almost_full_o is 1 exactly when occupancy is greater than or equal to af_level_i.
- R9: almost_empty_o is 1 exactly when occupancy is less than or equal to ae_level_i.
- R10: Words leave in the order they were accepted, including across address wrap-around from slot DEPTH-1 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low synchronous reset |
| fwft_mode_i | input | 1 | 0 = standard read latency, 1 = fall-through presentation |
| af_level_i | input | $clog2(DEPTH)+1 | Almost-full threshold (occupancy at or above) |
| ae_level_i | input | $clog2(DEPTH)+1 | Almost-empty threshold (occupancy at or below) |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Read data (registered in standard mode, head word in fall-through mode) |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| almost_full_o | output | 1 | Occupancy at or above af_level_i |
| almost_empty_o | output | 1 | Occupancy at or below ae_level_i |

## Verification
The properties assume that fwft_mode_i is held constant outside reset. They also assume af_level_i never exceeds DEPTH when the full-implies-almost-full rule is checked. The hold-while-idle rule for standard mode depends on the mode not switching under it. The bench respects this by setting the mode only while reset is asserted and by drawing thresholds from 0 to DEPTH. It freely issues writes on a full queue and reads on an empty one, because those requests are legal inputs whose effect the properties describe.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;

    typedef enum logic {
        MODE_STANDARD = 1'b0,
        MODE_FALLTHRU = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
    } fifo_op_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic almost_full;
        logic almost_empty;
    } fifo_flags_t;

endpackage

// File: rtl/fwft_fifo_ptr.sv
module fwft_fifo_ptr #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_req_i,
    input  logic                       rd_req_i,
    output fwft_fifo_pkg::fifo_op_t    op_o,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [ADDR_W-1:0]          rd_addr_o,
    output logic [CNT_W-1:0]           count_o
);
    import fwft_fifo_pkg::*;

    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  CAPACITY  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [ADDR_W-1:0] rptr;
        logic [CNT_W-1:0]  count;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    fifo_op_t   op;

    function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_d = state_q;
        op.push = wr_req_i && (state_q.count != CAPACITY);
        op.pop  = rd_req_i && (state_q.count != '0);
        if (op.push) begin
            state_d.wptr = bump(state_q.wptr);
        end
        if (op.pop) begin
            state_d.rptr = bump(state_q.rptr);
        end
        unique case ({op.push, op.pop})
            2'b10:   state_d.count = state_q.count + 1'b1;
            2'b01:   state_d.count = state_q.count - 1'b1;
            default: state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign op_o      = op;
    assign wr_addr_o = state_q.wptr;
    assign rd_addr_o = state_q.rptr;
    assign count_o   = state_q.count;

endmodule

// File: rtl/fwft_fifo_store.sv
module fwft_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (we_i && (waddr_i == ADDR_W'(g))) begin
                row_d = wdata_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign rows[g] = row_q;
    end

    always_comb begin
        rdata_o = rows[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_i == ADDR_W'(i)) begin
                rdata_o = rows[i];
            end
        end
    end

endmodule

// File: rtl/fwft_fifo_outstage.sv
module fwft_fifo_outstage #(
    parameter int DATA_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  fwft_fifo_pkg::out_mode_e   mode_i,
    input  logic                       pop_i,
    input  logic [DATA_W-1:0]          head_i,
    output logic [DATA_W-1:0]          data_o
);
    import fwft_fifo_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (pop_i) begin
            state_d.data = head_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign data_o = (mode_i == MODE_FALLTHRU) ? head_i : state_q.data;

endmodule

// File: rtl/fwft_fifo_flags.sv
module fwft_fifo_flags #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [CNT_W-1:0]              count_i,
    input  logic [CNT_W-1:0]              af_level_i,
    input  logic [CNT_W-1:0]              ae_level_i,
    output fwft_fifo_pkg::fifo_flags_t    flags_o
);
    import fwft_fifo_pkg::*;

    localparam logic [CNT_W-1:0] CAPACITY = CNT_W'(DEPTH);

    fifo_flags_t flags_d;

    always_comb begin
        flags_d              = '0;
        flags_d.full         = (count_i == CAPACITY);
        flags_d.empty        = (count_i == '0);
        flags_d.almost_full  = (count_i >= af_level_i);
        flags_d.almost_empty = (count_i <= ae_level_i);
    end

    assign flags_o = flags_d;

endmodule

// File: rtl/fwft_fifo_ctrl.sv
module fwft_fifo_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fwft_mode_i,
    input  logic [CNT_W-1:0]  af_level_i,
    input  logic [CNT_W-1:0]  ae_level_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              almost_full_o,
    output logic              almost_empty_o
);
    import fwft_fifo_pkg::*;

    fifo_op_t          op;
    fifo_flags_t       flags;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  occupancy;
    logic [DATA_W-1:0] head_word;
    out_mode_e         mode;

    assign mode = out_mode_e'(fwft_mode_i);

    fwft_fifo_ptr #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_ptr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_req_i  (wr_en_i),
        .rd_req_i  (rd_en_i),
        .op_o      (op),
        .wr_addr_o (wr_addr),
        .rd_addr_o (rd_addr),
        .count_o   (occupancy)
    );

    fwft_fifo_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (op.push),
        .waddr_i (wr_addr),
        .wdata_i (wr_data_i),
        .raddr_i (rd_addr),
        .rdata_o (head_word)
    );

    fwft_fifo_outstage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (mode),
        .pop_i  (op.pop),
        .head_i (head_word),
        .data_o (rd_data_o)
    );

    fwft_fifo_flags #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_flags (
        .count_i    (occupancy),
        .af_level_i (af_level_i),
        .ae_level_i (ae_level_i),
        .flags_o    (flags)
    );

    assign full_o         = flags.full;
    assign empty_o        = flags.empty;
    assign almost_full_o  = flags.almost_full;
    assign almost_empty_o = flags.almost_empty;

endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              fwft_mode_i,
    input logic [CNT_W-1:0]  af_level_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              full_o,
    input logic              empty_o,
    input logic              almost_full_o,
    input logic              almost_empty_o,
    input logic [CNT_W-1:0]  occupancy
);

    // R2: full and empty never together
    assert_flags_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(full_o && empty_o));

    // R2: occupancy moves by at most one per cycle
    assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occupancy == $past(occupancy)) ||
        (occupancy == $past(occupancy) + 1'b1) ||
        (occupancy + 1'b1 == $past(occupancy)));

    // R3: a lone write on a full queue changes nothing
    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && wr_en_i && !rd_en_i) |=> (full_o && $stable(occupancy)));

    // R4: a lone read on an empty queue changes nothing
    assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (empty_o && rd_en_i && !wr_en_i) |=> (empty_o && $stable(occupancy)));

    // R5: standard-mode output holds without an accepted read
    assert_std_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fwft_mode_i && !(rd_en_i && !empty_o)) |=> $stable(rd_data_o));

    // R6: fall-through shows the first word right after it is stored
    assert_fwft_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwft_mode_i && empty_o && wr_en_i) |=> (!empty_o && rd_data_o == $past(wr_data_i)));

    // R7: balanced traffic keeps occupancy
    assert_balanced_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && rd_en_i && !full_o && !empty_o) |=> $stable(occupancy));

    // R8: full implies almost full for any reachable threshold
    assert_full_almost_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && (af_level_i <= CNT_W'(DEPTH))) |-> almost_full_o);

    // R9: empty implies almost empty
    assert_empty_almost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> almost_empty_o);

endmodule

bind fwft_fifo_ctrl fwft_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_fwft_fifo_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fwft_mode_i    (fwft_mode_i),
    .af_level_i     (af_level_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_en_i        (rd_en_i),
    .rd_data_o      (rd_data_o),
    .full_o         (full_o),
    .empty_o        (empty_o),
    .almost_full_o  (almost_full_o),
    .almost_empty_o (almost_empty_o),
    .occupancy      (occupancy)
);

// File: tb/test_fwft_fifo_ctrl.sv
module test_fwft_fifo_ctrl;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fwft = 1'b0;
    logic [CNT_W-1:0]  af_lvl = 3;
    logic [CNT_W-1:0]  ae_lvl = 1;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              full, empty, afull, aempty;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int mq [DEPTH];
    int mh = 0;
    int mc = 0;
    logic [DATA_W-1:0] exp_data = '0;
    logic [DATA_W-1:0] next_word = 8'h11;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    fwft_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fwft_fifo_ctrl (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .fwft_mode_i    (fwft),
        .af_level_i     (af_lvl),
        .ae_level_i     (ae_lvl),
        .wr_en_i        (wr_en),
        .wr_data_i      (wr_data),
        .rd_en_i        (rd_en),
        .rd_data_o      (rd_data),
        .full_o         (full),
        .empty_o        (empty),
        .almost_full_o  (afull),
        .almost_empty_o (aempty)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "full", int'(full), int'(mc == DEPTH));
        check(tag, "empty", int'(empty), int'(mc == 0));
        check("R8", "almost_full", int'(afull), int'(mc >= int'(af_lvl)));
        check("R9", "almost_empty", int'(aempty), int'(mc <= int'(ae_lvl)));
        if (!fwft) begin
            check("R5/R10", "rd_data", int'(rd_data), int'(exp_data));
        end else if (mc > 0) begin
            check("R6/R10", "rd_data", int'(rd_data), mq[mh]);
        end
    endtask

    task automatic step(input logic w, input logic r, input string tag);
        bit pw, pr;
        int tail;
        wr_en   = w;
        rd_en   = r;
        wr_data = next_word;
        pw   = w && (mc < DEPTH);
        pr   = r && (mc > 0);
        tail = (mh + mc) % DEPTH;
        @(posedge clk);
        if (pw) begin
            mq[tail] = int'(next_word);
        end
        if (pr) begin
            if (!fwft) exp_data = DATA_W'(mq[mh]);
            mh = (mh + 1) % DEPTH;
        end
        mc = mc + int'(pw) - int'(pr);
        next_word = next_word + 8'd7;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        fwft  = mode;
        af_lvl = 3;
        ae_lvl = 1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mh = 0;
        mc = 0;
        exp_data = '0;
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "almost_empty", int'(aempty), 1);
        check("R1", "almost_full", int'(afull), 0);
        if (!mode) check("R1", "rd_data", int'(rd_data), 0);
    endtask

    task automatic run_mode(input logic mode);
        do_reset(mode);
        // R4: reads on empty queue ignored
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        // R6: first word visible without a read (fall-through); R2 single write
        step(1'b1, 1'b0, "R2");
        // R2/R3: fill up then push against full
        for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b0, "R3");
        // R7: both at full, only read happens
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, "R2");
        // R10: drain in order, dropped words absent
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R10");
        step(1'b0, 1'b1, "R4");
        // R7: both at empty, only write happens
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, "R2");
        // R7: balanced traffic in the middle
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R7");
        // sweep: thresholds and traffic mixes, biased fill/drain phases
        for (int ph = 0; ph < 12; ph++) begin
            for (int k = 0; k < 30; k++) begin
                logic w, r;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                af_lvl = CNT_W'(int'(lfsr[6:4]) % (DEPTH + 1));
                ae_lvl = CNT_W'(int'(lfsr[10:8]) % (DEPTH + 1));
                if (ph[0]) begin
                    w = lfsr[0] && lfsr[1];
                    r = lfsr[2] || lfsr[3];
                end else begin
                    w = lfsr[0] || lfsr[1];
                    r = lfsr[2] && lfsr[3];
                end
                step(w, r, "R2");
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        finish_run();
    end

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule